// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a list of up to sixteen queued transfers without processor help. Software fills two small memories through a byte-wide register port. The command memory holds one byte per entry, and that byte picks the peripheral chip-select line. The transmit memory holds the outgoing byte for each entry. Software then sets a start index, an end index and a clock divisor, and sets the run bit.

From that point the sequencer fetches each entry in turn and shifts the byte out on MOSI. At the same time it samples MISO and stores the incoming byte in a receive memory slot with the same index as the entry. After the end entry it raises a completion flag. It then either stops, or starts again at the start index if wrapping is enabled. A halt request is honoured only between transfers and is acknowledged by a separate flag.

Bus map (6-bit address):

| Address | Contents |
|---|---|
| 0x00–0x0F | transmit memory |
| 0x10–0x1F | command memory |
| 0x20–0x2F | receive memory |
| 0x30 | divisor |
| 0x31 | start index |
| 0x32 | end index |
| 0x33 | interrupt enable, bit 0 |
| 0x34 | wrap enable, bit 0 |
| 0x35 | run control: bit 0 run, bit 1 halt request |
| 0x36 | status: bit 0 done, bit 1 halt acknowledged |

Top module: `qspi_master`

## Requirements
- R1: After reset the divisor reads 4, start/end/ien/wrap/run/status read 0, receive memory reads 0, `pcs_n` is 4'hF, `sck` is 0 and `irq` is 0.
- R2: Each transfer is 8 bits in mode 0. `sck` idles low and has exactly 8 rising edges, spaced 2×divisor clock cycles apart. MOSI is sent MSB first and changes only after falling edges.
- R3: MISO is sampled on each rising edge of `sck`, MSB first. The received byte is stored at receive address 0x20 plus the entry index.
- R4: Command bits [1:0] select the chip-select line. During a transfer exactly that bit of `pcs_n` is low. Between transfers all four bits are high.
- R5: With run set, entries start, start+1, … (indices modulo 16) through end are executed in order. Afterwards status bit 0 is set and, without wrap, run bit 0 is cleared by hardware.
- R6: With wrap enabled, the entry after the end entry is the start entry again. Status bit 0 is still set at each pass.
- R7: A divisor of 0 or 1 starts no transfer: `sck` stays low, `pcs_n` stays high and run stays set. Writing a legal divisor then lets the queue proceed.
- R8: Setting halt request (run bit 1) lets the current transfer finish. No further transfer starts, and status bit 1 is set. Clearing halt resumes with the next entry.
- R9: End index and divisor writes made during a transfer do not change that transfer's length, clock or end decision. They are used from the next transfer.
- R10: Status bits are set only by hardware. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R11: `irq` is high exactly when status bit 0 and interrupt enable are both 1.
- R12: Bus writes to the receive memory region are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_we | input | 1 | register/memory write strobe |
| bus_addr | input | 6 | register/memory address |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data for `bus_addr` |
| sck | output | 1 | serial clock |
| mosi | output | 1 | serial data out |
| miso | input | 1 | serial data in |
| pcs_n | output | 4 | active-low peripheral chip selects |
| irq | output | 1 | completion interrupt |

## Verification
The bench writes the end index and the divisor in the middle of a final transfer. A design that failed to latch them would stretch the queue or change the clock period of the transfer already in flight. It raises halt during a transfer and expects exactly one more transfer, followed by a clean resume at the next index. A design that halted mid-byte or skipped an entry would show a short byte or a missing index. Other targets are:
- queues that wrap past index 15;
- the wrap path repeating the start entry;
- the divisor values 0 and 1, where a careless design would still toggle `sck`;
- write-0 and write-1 behaviour of the status flags;
- writes into the receive area, which must leave captured data intact.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  // Address regions selected by the two top address bits
  localparam int unsigned REGION_TX  = 0;
  localparam int unsigned REGION_CMD = 1;
  localparam int unsigned REGION_RX  = 2;
  localparam int unsigned REGION_CTL = 3;

  // Offsets inside the control region
  localparam int OFS_DIV   = 0;
  localparam int OFS_START = 1;
  localparam int OFS_END   = 2;
  localparam int OFS_IEN   = 3;
  localparam int OFS_WRAP  = 4;
  localparam int OFS_RUN   = 5;
  localparam int OFS_STAT  = 6;

  localparam int DIV_RESET = 4;
  localparam int DIV_MIN   = 2;

  typedef enum logic [1:0] {
    SQ_OFF,
    SQ_READY,
    SQ_XFER,
    SQ_HALT
  } seq_state_e;
endpackage

// File: rtl/qspi_regfile.sv
module qspi_regfile
  import qspi_pkg::*;
#(
  parameter int QDEPTH = 16,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int CS_W   = 2,
  localparam int PTR_W  = $clog2(QDEPTH),
  localparam int ADDR_W = PTR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_we,
  input  logic [PTR_W-1:0]  rx_idx,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              set_fin,
  input  logic              set_hack,
  input  logic              clr_en,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] tx_word,
  output logic [CS_W-1:0]   cs_sel,
  output logic [DIV_W-1:0]  div,
  output logic [PTR_W-1:0]  start_ptr,
  output logic [PTR_W-1:0]  end_ptr,
  output logic              wrap_en,
  output logic              run_en,
  output logic              halt_req,
  output logic              irq
);
  logic [DATA_W-1:0] tx_mem  [QDEPTH];
  logic [DATA_W-1:0] cmd_mem [QDEPTH];
  logic [DATA_W-1:0] rx_mem  [QDEPTH];

  logic [1:0]       region;
  logic [PTR_W-1:0] slot;
  logic             wr_tx, wr_cmd, wr_ctl;

  assign region = bus_addr[ADDR_W-1 -: 2];
  assign slot   = bus_addr[PTR_W-1:0];
  assign wr_tx  = bus_we && (region == 2'(REGION_TX));
  assign wr_cmd = bus_we && (region == 2'(REGION_CMD));
  assign wr_ctl = bus_we && (region == 2'(REGION_CTL));
  // receive region has no bus write path

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < QDEPTH; i++) begin
        tx_mem[i]  <= '0;
        cmd_mem[i] <= '0;
        rx_mem[i]  <= '0;
      end
    end else begin
      if (wr_tx)  tx_mem[slot]  <= bus_wdata;
      if (wr_cmd) cmd_mem[slot] <= bus_wdata;
      if (rx_we)  rx_mem[rx_idx] <= rx_data;
    end
  end

  logic [DIV_W-1:0] div_q, div_d;
  logic [PTR_W-1:0] start_q, start_d, end_q, end_d;
  logic ien_q, ien_d, wrap_q, wrap_d, en_q, en_d, halt_q, halt_d;
  logic fin_q, fin_d, hack_q, hack_d;

  always_comb begin
    div_d   = div_q;
    start_d = start_q;
    end_d   = end_q;
    ien_d   = ien_q;
    wrap_d  = wrap_q;
    en_d    = en_q;
    halt_d  = halt_q;
    fin_d   = fin_q;
    hack_d  = hack_q;
    if (wr_ctl) begin
      case (int'(slot))
        OFS_DIV:   div_d   = bus_wdata[DIV_W-1:0];
        OFS_START: start_d = bus_wdata[PTR_W-1:0];
        OFS_END:   end_d   = bus_wdata[PTR_W-1:0];
        OFS_IEN:   ien_d   = bus_wdata[0];
        OFS_WRAP:  wrap_d  = bus_wdata[0];
        OFS_RUN: begin
          en_d   = bus_wdata[0];
          halt_d = bus_wdata[1];
        end
        OFS_STAT: begin
          if (bus_wdata[0]) fin_d  = 1'b0;
          if (bus_wdata[1]) hack_d = 1'b0;
        end
        default: ;
      endcase
    end
    if (clr_en && !(wr_ctl && int'(slot) == OFS_RUN)) en_d = 1'b0;
    if (set_fin)  fin_d  = 1'b1;
    if (set_hack) hack_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= DIV_W'(DIV_RESET);
      start_q <= '0;
      end_q   <= '0;
      ien_q   <= 1'b0;
      wrap_q  <= 1'b0;
      en_q    <= 1'b0;
      halt_q  <= 1'b0;
      fin_q   <= 1'b0;
      hack_q  <= 1'b0;
    end else begin
      div_q   <= div_d;
      start_q <= start_d;
      end_q   <= end_d;
      ien_q   <= ien_d;
      wrap_q  <= wrap_d;
      en_q    <= en_d;
      halt_q  <= halt_d;
      fin_q   <= fin_d;
      hack_q  <= hack_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (int'(region))
      REGION_TX:  bus_rdata = tx_mem[slot];
      REGION_CMD: bus_rdata = cmd_mem[slot];
      REGION_RX:  bus_rdata = rx_mem[slot];
      default: begin
        case (int'(slot))
          OFS_DIV:   bus_rdata = DATA_W'(div_q);
          OFS_START: bus_rdata = DATA_W'(start_q);
          OFS_END:   bus_rdata = DATA_W'(end_q);
          OFS_IEN:   bus_rdata = DATA_W'(ien_q);
          OFS_WRAP:  bus_rdata = DATA_W'(wrap_q);
          OFS_RUN:   bus_rdata = DATA_W'({halt_q, en_q});
          OFS_STAT:  bus_rdata = DATA_W'({hack_q, fin_q});
          default:   bus_rdata = '0;
        endcase
      end
    endcase
  end

  assign tx_word   = tx_mem[rd_idx];
  assign cs_sel    = cmd_mem[rd_idx][CS_W-1:0];
  assign div       = div_q;
  assign start_ptr = start_q;
  assign end_ptr   = end_q;
  assign wrap_en   = wrap_q;
  assign run_en    = en_q;
  assign halt_req  = halt_q;
  assign irq       = fin_q & ien_q;

  // R10
  fin_only_hw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin_q) |-> $past(set_fin));
  // R10
  hack_only_hw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hack_q) |-> $past(set_hack));
endmodule

// File: rtl/qspi_shifter.sv
module qspi_shifter #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int NUM_CS = 4,
  localparam int CS_W      = $clog2(NUM_CS),
  localparam int LAST_HALF = 2 * DATA_W - 1,
  localparam int HALF_W    = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIV_W-1:0]  div,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [CS_W-1:0]   cs_sel,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi,
  output logic [NUM_CS-1:0] pcs_n
);
  logic              busy_q, busy_d, done_q, done_d, sck_q, sck_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d, divl_q, divl_d;
  logic [HALF_W-1:0] half_q, half_d;
  logic [DATA_W-1:0] sh_q, sh_d, rx_q, rx_d;
  logic [CS_W-1:0]   cs_q, cs_d;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    sck_d  = sck_q;
    cnt_d  = cnt_q;
    divl_d = divl_q;
    half_d = half_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    cs_d   = cs_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        half_d = '0;
        sck_d  = 1'b0;
        sh_d   = tx_word;
        rx_d   = '0;
        cs_d   = cs_sel;
        divl_d = div;
      end
    end else if (cnt_q == divl_q - DIV_W'(1)) begin
      cnt_d  = '0;
      half_d = half_q + HALF_W'(1);
      sck_d  = ~sck_q;
      if (!sck_q) begin
        rx_d = {rx_q[DATA_W-2:0], miso};
      end else begin
        sh_d = sh_q << 1;
        if (half_q == HALF_W'(LAST_HALF)) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      divl_q <= '0;
      half_q <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      cs_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      sck_q  <= sck_d;
      cnt_q  <= cnt_d;
      divl_q <= divl_d;
      half_q <= half_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      cs_q   <= cs_d;
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign pcs_n[g] = !(busy_q && (cs_q == CS_W'(g)));
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_word = rx_q;
  assign sck     = sck_q;
  assign mosi    = sh_q[DATA_W-1];

  // R2
  sck_only_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> busy_q);
  // R4
  single_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~pcs_n));
endmodule

// File: rtl/qspi_sequencer.sv
module qspi_sequencer
  import qspi_pkg::*;
#(
  parameter int QDEPTH = 16,
  parameter int DIV_W  = 8,
  localparam int PTR_W = $clog2(QDEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             halt_req,
  input  logic             wrap_en,
  input  logic [PTR_W-1:0] start_ptr,
  input  logic [PTR_W-1:0] end_ptr,
  input  logic [DIV_W-1:0] div,
  input  logic             shift_busy,
  input  logic             shift_done,
  output logic [PTR_W-1:0] ptr,
  output logic             xfer_start,
  output logic             rx_we,
  output logic             set_fin,
  output logic             set_hack,
  output logic             clr_en
);
  seq_state_e       state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d, endl_q, endl_d;

  always_comb begin
    state_d    = state_q;
    ptr_d      = ptr_q;
    endl_d     = endl_q;
    xfer_start = 1'b0;
    rx_we      = 1'b0;
    set_fin    = 1'b0;
    set_hack   = 1'b0;
    clr_en     = 1'b0;
    unique case (state_q)
      SQ_OFF: begin
        if (run_en) begin
          ptr_d   = start_ptr;
          state_d = SQ_READY;
        end
      end
      SQ_READY: begin
        if (!run_en) begin
          state_d = SQ_OFF;
        end else if (halt_req) begin
          set_hack = 1'b1;
          state_d  = SQ_HALT;
        end else if (div >= DIV_W'(DIV_MIN)) begin
          xfer_start = 1'b1;
          endl_d     = end_ptr;
          state_d    = SQ_XFER;
        end
      end
      SQ_XFER: begin
        if (shift_done) begin
          rx_we = 1'b1;
          if (ptr_q == endl_q) begin
            set_fin = 1'b1;
            ptr_d   = start_ptr;
            if (wrap_en) begin
              state_d = SQ_READY;
            end else begin
              clr_en  = 1'b1;
              state_d = SQ_OFF;
            end
          end else begin
            ptr_d   = ptr_q + PTR_W'(1);
            state_d = SQ_READY;
          end
        end
      end
      SQ_HALT: begin
        if (!run_en)        state_d = SQ_OFF;
        else if (!halt_req) state_d = SQ_READY;
      end
      default: state_d = SQ_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_OFF;
      ptr_q   <= '0;
      endl_q  <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      endl_q  <= endl_d;
    end
  end

  assign ptr = ptr_q;

  // R8
  halt_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_HALT) |-> !shift_busy);
  // R5
  stop_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_XFER && shift_done && ptr_q == endl_q && !wrap_en) |=> !run_en);
endmodule

// File: rtl/qspi_master.sv
module qspi_master #(
  parameter int QDEPTH = 16,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int NUM_CS = 4,
  localparam int PTR_W  = $clog2(QDEPTH),
  localparam int ADDR_W = PTR_W + 2,
  localparam int CS_W   = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] pcs_n,
  output logic              irq
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [PTR_W-1:0]  ptr, start_ptr, end_ptr;
  logic [DIV_W-1:0]  div;
  logic [DATA_W-1:0] tx_word, rx_word;
  logic [CS_W-1:0]   cs_sel;
  logic wrap_en, run_en, halt_req;
  logic xfer_start, rx_we, set_fin, set_hack, clr_en;
  logic sh_busy, sh_done;

  qspi_regfile #(.QDEPTH(QDEPTH), .DATA_W(DATA_W), .DIV_W(DIV_W), .CS_W(CS_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_we(rx_we), .rx_idx(ptr), .rx_data(rx_word),
    .set_fin(set_fin), .set_hack(set_hack), .clr_en(clr_en),
    .rd_idx(ptr), .tx_word(tx_word), .cs_sel(cs_sel),
    .div(div), .start_ptr(start_ptr), .end_ptr(end_ptr),
    .wrap_en(wrap_en), .run_en(run_en), .halt_req(halt_req), .irq(irq)
  );

  qspi_sequencer #(.QDEPTH(QDEPTH), .DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst_n(rst_core_n),
    .run_en(run_en), .halt_req(halt_req), .wrap_en(wrap_en),
    .start_ptr(start_ptr), .end_ptr(end_ptr), .div(div),
    .shift_busy(sh_busy), .shift_done(sh_done),
    .ptr(ptr), .xfer_start(xfer_start), .rx_we(rx_we),
    .set_fin(set_fin), .set_hack(set_hack), .clr_en(clr_en)
  );

  qspi_shifter #(.DATA_W(DATA_W), .DIV_W(DIV_W), .NUM_CS(NUM_CS)) u_shift (
    .clk(clk), .rst_n(rst_core_n),
    .start(xfer_start), .div(div), .tx_word(tx_word), .cs_sel(cs_sel), .miso(miso),
    .busy(sh_busy), .done(sh_done), .rx_word(rx_word),
    .sck(sck), .mosi(mosi), .pcs_n(pcs_n)
  );

  // R7
  legal_div_at_launch_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(sh_busy) |-> ($past(div) >= DIV_W'(2)));
endmodule

// File: tb/qspi_master_test.sv
`timescale 1ns/1ps
module qspi_master_test;
  localparam logic [5:0] A_TX = 6'h00, A_CMD = 6'h10, A_RX = 6'h20;
  localparam logic [5:0] A_DIV = 6'h30, A_START = 6'h31, A_END = 6'h32;
  localparam logic [5:0] A_IEN = 6'h33, A_WRAP = 6'h34, A_RUN = 6'h35, A_STAT = 6'h36;

  logic clk = 1'b0;
  logic rst_n, bus_we, miso, sck, mosi, irq;
  logic [5:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [3:0] pcs_n;

  always #10 clk = ~clk;

  qspi_master uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .pcs_n(pcs_n), .irq(irq)
  );

  int n_checks = 0, n_fail = 0;
  logic [7:0] resp_tab [64];
  logic [7:0] tx_sh [16];
  logic [7:0] cmd_sh [16];
  int exp_idx [32];
  int exp_div [32];

  // slave model and transfer monitor (sole writer of these)
  int n_xfer = 0;
  int log_cs [512], log_rises [512], log_per [512];
  bit log_even [512], log_one [512];
  logic [7:0] log_mosi [512];
  int cyc, last_rise, cur_per, rises, bitpos, cs_now;
  bit even, one_hot, idle_bad = 1'b0;
  logic [7:0] cur_mosi, cur_resp;
  logic sck_p = 1'b0;
  logic [3:0] pcs_p = 4'hF;

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (pcs_n == 4'hF && sck) idle_bad = 1'b1;
      if (pcs_n != 4'hF && pcs_p == 4'hF) begin
        cs_now = -1;
        for (int i = 0; i < 4; i++) if (!pcs_n[i]) cs_now = i;
        one_hot = ($countones(~pcs_n) == 1);
        cyc = 0; last_rise = -1; cur_per = 0; rises = 0; even = 1'b1;
        cur_mosi = 8'h00; bitpos = 7;
        cur_resp = resp_tab[n_xfer & 63];
        miso = cur_resp[7];
      end
      if (pcs_n != 4'hF) begin
        cyc++;
        if (sck && !sck_p) begin
          cur_mosi = {cur_mosi[6:0], mosi};
          rises++;
          if (last_rise >= 0) begin
            if (cur_per != 0 && cur_per != cyc - last_rise) even = 1'b0;
            cur_per = cyc - last_rise;
          end
          last_rise = cyc;
        end
        if (!sck && sck_p && bitpos > 0) begin
          bitpos--;
          miso = cur_resp[bitpos];
        end
      end
      if (pcs_n == 4'hF && pcs_p != 4'hF) begin
        log_cs[n_xfer & 511]    = cs_now;
        log_one[n_xfer & 511]   = one_hot;
        log_mosi[n_xfer & 511]  = cur_mosi;
        log_rises[n_xfer & 511] = rises;
        log_per[n_xfer & 511]   = cur_per;
        log_even[n_xfer & 511]  = even;
        n_xfer++;
        miso = 1'b0;
      end
      sck_p = sck;
      pcs_p = pcs_n;
    end
  end

  function automatic int queue_len(input int s, input int e);
    return ((e - s) & 15) + 1;
  endfunction

  function automatic int irq_expect(input bit fin, input bit ien);
    return (fin && ien) ? 1 : 0;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_fin(input string tag);
    logic [7:0] s;
    int t = 0;
    s = 8'h00;
    while (!s[0] && t < 20000) begin
      rd(A_STAT, s);
      t++;
    end
    chk(s[0] == 1'b1, tag, s, 1);
  endtask

  task automatic fill_mem;
    for (int i = 0; i < 16; i++) begin
      tx_sh[i]  = 8'($urandom);
      cmd_sh[i] = 8'($urandom);
      wr(A_TX | 6'(i), tx_sh[i]);
      wr(A_CMD | 6'(i), cmd_sh[i]);
    end
  endtask

  task automatic verify(input int base, input int cnt);
    for (int k = 0; k < cnt; k++) begin
      int g, idx;
      g = (base + k) & 511;
      idx = exp_idx[k];
      chk(log_cs[g] == int'(cmd_sh[idx][1:0]), "R4 selected chip select", log_cs[g], cmd_sh[idx][1:0]);
      chk(log_one[g], "R4 single active select", 0, 1);
      chk(log_mosi[g] == tx_sh[idx], "R2 mosi byte MSB first", log_mosi[g], tx_sh[idx]);
      chk(log_rises[g] == 8, "R2 rising edge count", log_rises[g], 8);
      chk(log_even[g] && log_per[g] == 2 * exp_div[k], "R2 sck period", log_per[g], 2 * exp_div[k]);
    end
  endtask

  initial begin
    logic [7:0] d;
    int base, s, e, dv, ien, cnt;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; miso = 1'b0;
    void'($urandom(32'd5171));
    for (int i = 0; i < 64; i++) resp_tab[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_DIV, d);   chk(d == 8'd4, "R1 divisor reset", d, 4);
    rd(A_STAT, d);  chk(d == 8'd0, "R1 status reset", d, 0);
    rd(A_RUN, d);   chk(d == 8'd0, "R1 run reset", d, 0);
    rd(A_START, d); chk(d == 8'd0, "R1 start reset", d, 0);
    rd(A_RX | 6'd9, d); chk(d == 8'd0, "R1 receive reset", d, 0);
    chk(pcs_n == 4'hF, "R1 pcs idle", pcs_n, 4'hF);
    chk(sck == 1'b0, "R1 sck idle", sck, 0);
    chk(irq == 1'b0, "R1 irq idle", irq, 0);

    // R12 receive region is not bus writable
    wr(A_RX | 6'd3, 8'hA5);
    rd(A_RX | 6'd3, d); chk(d == 8'd0, "R12 receive write ignored", d, 0);

    // R3 R5 R11 random queues
    fill_mem;
    for (int r = 0; r < 4; r++) begin
      s = (r == 0) ? 14 : int'($urandom % 16);
      e = (r == 0) ? 2 : int'($urandom % 16);
      dv = 2 + int'($urandom % 5);
      ien = int'($urandom % 2);
      cnt = queue_len(s, e);
      for (int k = 0; k < cnt; k++) begin
        exp_idx[k] = (s + k) & 15;
        exp_div[k] = dv;
      end
      wr(A_DIV, 8'(dv)); wr(A_START, 8'(s)); wr(A_END, 8'(e)); wr(A_IEN, 8'(ien));
      base = n_xfer;
      wr(A_RUN, 8'h01);
      wait_fin("R5 queue completes");
      repeat (3) @(negedge clk);
      chk(n_xfer - base == cnt, "R5 transfer count", n_xfer - base, cnt);
      verify(base, cnt);
      for (int k = 0; k < cnt; k++) begin
        rd(A_RX | 6'(exp_idx[k]), d);
        chk(d == resp_tab[(base + k) & 63], "R3 received byte stored", d, resp_tab[(base + k) & 63]);
      end
      rd(A_RUN, d); chk(d[0] == 1'b0, "R5 run cleared at end", d, 0);
      chk(int'(irq) == irq_expect(1'b1, ien[0]), "R11 irq follows enable", irq, ien);
      // R12 overwrite attempt on captured data
      wr(A_RX | 6'(exp_idx[0]), ~resp_tab[base & 63]);
      rd(A_RX | 6'(exp_idx[0]), d);
      chk(d == resp_tab[base & 63], "R12 captured data kept", d, resp_tab[base & 63]);
      wr(A_STAT, 8'h00);
      rd(A_STAT, d); chk(d[0] == 1'b1, "R10 write 0 keeps flag", d, 1);
      wr(A_STAT, 8'h01);
      rd(A_STAT, d); chk(d == 8'h00, "R10 write 1 clears flag", d, 0);
      chk(irq == 1'b0, "R11 irq drops with flag", irq, 0);
    end
    wr(A_IEN, 8'h00);

    // R7 illegal divisors hold the queue
    for (int v = 0; v < 2; v++) begin
      wr(A_DIV, 8'(v)); wr(A_START, 8'd5); wr(A_END, 8'd5);
      base = n_xfer;
      wr(A_RUN, 8'h01);
      repeat (100) @(negedge clk);
      chk(n_xfer == base, "R7 no transfer at divisor 0/1", n_xfer - base, 0);
      chk(sck == 1'b0 && pcs_n == 4'hF, "R7 pins idle", {sck, pcs_n}, 5'h0F);
      rd(A_RUN, d); chk(d[0] == 1'b1, "R7 run stays set", d, 1);
      wr(A_DIV, 8'd3);
      wait_fin("R7 legal divisor resumes");
      repeat (3) @(negedge clk);
      exp_idx[0] = 5; exp_div[0] = 3;
      chk(n_xfer - base == 1, "R7 one transfer", n_xfer - base, 1);
      verify(base, 1);
      wr(A_STAT, 8'h01);
    end

    // R9 writes during the last transfer apply later
    wr(A_DIV, 8'd8); wr(A_START, 8'd0); wr(A_END, 8'd1);
    base = n_xfer;
    wr(A_RUN, 8'h01);
    while (!(n_xfer == base + 1 && pcs_n != 4'hF)) @(negedge clk);
    wr(A_END, 8'd5);
    wr(A_DIV, 8'd2);
    wait_fin("R9 queue completes");
    repeat (40) @(negedge clk);
    chk(n_xfer - base == 2, "R9 end index latched", n_xfer - base, 2);
    chk(log_per[(base + 1) & 511] == 16, "R9 divisor latched", log_per[(base + 1) & 511], 16);
    wr(A_STAT, 8'h01);

    // R6 wrap repeats from the start index
    wr(A_DIV, 8'd2); wr(A_START, 8'd3); wr(A_END, 8'd4); wr(A_WRAP, 8'd1);
    base = n_xfer;
    wr(A_RUN, 8'h01);
    while (n_xfer < base + 5) @(negedge clk);
    wr(A_RUN, 8'h00);
    repeat (80) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      exp_idx[k] = (k % 2 == 0) ? 3 : 4;
      exp_div[k] = 2;
    end
    verify(base, 5);
    rd(A_STAT, d); chk(d[0] == 1'b1, "R6 done flag on wrap", d, 1);
    chk(pcs_n == 4'hF, "R6 stops when run cleared", pcs_n, 4'hF);
    wr(A_WRAP, 8'd0); wr(A_STAT, 8'h01);

    // R8 halt only between transfers
    wr(A_START, 8'd0); wr(A_END, 8'd7);
    base = n_xfer;
    wr(A_RUN, 8'h01);
    while (!(n_xfer == base + 2 && pcs_n != 4'hF)) @(negedge clk);
    wr(A_RUN, 8'h03);
    repeat (150) @(negedge clk);
    chk(n_xfer - base == 3, "R8 current transfer finishes", n_xfer - base, 3);
    chk(pcs_n == 4'hF, "R8 no new transfer", pcs_n, 4'hF);
    rd(A_STAT, d); chk(d == 8'h02, "R8 halt acknowledged", d, 2);
    wr(A_RUN, 8'h01);
    wait_fin("R8 resumed queue completes");
    repeat (3) @(negedge clk);
    chk(n_xfer - base == 8, "R8 resume count", n_xfer - base, 8);
    for (int k = 0; k < 8; k++) begin
      exp_idx[k] = k;
      exp_div[k] = 2;
    end
    verify(base, 8);
    rd(A_STAT, d); chk(d == 8'h03, "R10 flags sticky", d, 3);
    wr(A_STAT, 8'h02);
    rd(A_STAT, d); chk(d == 8'h01, "R10 clear halt flag only", d, 1);
    wr(A_STAT, 8'h01);
    chk(!idle_bad, "R2 sck low outside transfers", idle_bad, 0);

    report;
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    report;
    $finish;
  end
endmodule